// File: doc/BRIEF.md
# GPIO Port Register File

This block holds the software-visible state of one general-purpose I/O port of eight pins. A 32-bit memory-mapped bus with a single select, a write strobe and a word address reaches four registers. A combined data word carries the pin directions, the output levels, a snapshot of the pins taken just after reset, and the live input levels. Two write-only alias words change output bits without a read-modify-write. A 1 in a lane bit acts on its pin, and a 0 leaves that pin alone. A configuration word carries per-pin drive strength and pull-up disable controls. Its drive-strength field can be written only once after each reset.

Pins reach the register file through a two-flop synchronizer. The block drives per-pin output-enable and output-level lines, and the drive and pull-up controls, toward the pad logic. Reads are registered: a read issued on one clock edge presents its word on `rdata_o` until the next edge.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is low and right after it rises, `oe_o`, `out_o`, `drv_o`, `pu_dis_o` and `rdata_o` are all zero.
- R2: A write to byte offset 0x0 loads bits [31:24] into the pin directions on `oe_o` (1 = output) and bits [23:16] into `out_o`. Both take effect on the write's clock edge. Bits [15:0] of that write are ignored.
- R3: A read of offset 0x0 is captured on its clock edge and shows `{direction, output, snapshot, input}` in bytes [31:24], [23:16], [15:8] and [7:0] of `rdata_o`.
- R4: A read captured on edge k shows, in bits [7:0], the pin levels sampled on edge k-2. A read captured on the first edge after a pin change still shows the old level.
- R5: Bits [15:8] of offset 0x0 hold the pin levels sampled on the first clock edge after reset is released. Later pin changes leave them unchanged until the next reset.
- R6: A write to offset 0x4 sets every output bit whose bit in [23:16] is 1 and leaves the other output bits alone. Bits [31:24] and [15:0] of the write, and the directions, are untouched.
- R7: A write to offset 0x8 clears every output bit whose bit in [23:16] is 1 and leaves the other output bits alone. Bits [31:24] and [15:0] of the write, and the directions, are untouched.
- R8: Reads of offsets 0x4, 0x8 and of any offset from 0x10 to 0x1C return zero. Writes to offsets 0x10 to 0x1C change no register.
- R9: Offset 0xC holds drive strength in bits [15:8] (on `drv_o`) and pull-up disable in bits [7:0] (on `pu_dis_o`). It reads back as `{16'h0, drive, pull-up}`. The pull-up field accepts every write.
- R10: Only the first write to offset 0xC after reset loads the drive-strength field. Later writes leave it unchanged, and only a reset lets it be loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address inside the port window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 8 | Asynchronous pin levels from the pads |
| oe_o | output | 8 | Per-pin output enable |
| out_o | output | 8 | Per-pin output level |
| drv_o | output | 8 | Per-pin drive strength control |
| pu_dis_o | output | 8 | Per-pin pull-up disable |

## Verification
Register writes show on the pad outputs one edge after they are driven. A read word is captured on its edge and held until the next edge. An input change needs two edges to reach the readable input byte. The snapshot settles on the third edge after reset release. The bench drives bus inputs and pins on falling edges and samples outputs on the falling edge after the capturing rising edge. For the input latency, it reads once on the edge where the old level must still appear and once on the following edge where the new level must appear. Every write sweep is checked both on the pad outputs and through a readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte lanes of the data word
  localparam int LANE_IN   = 0;
  localparam int LANE_SNAP = 1;
  localparam int LANE_OUT  = 2;
  localparam int LANE_DIR  = 3;

  // Lanes of the configuration word
  localparam int LANE_PUD  = 0;
  localparam int LANE_DRV  = 1;

  // Word indices inside the window
  localparam int WORD_DATA = 0;
  localparam int WORD_SET  = 1;
  localparam int WORD_CLR  = 2;
  localparam int WORD_CFG  = 3;

  typedef enum logic [2:0] {
    REG_DATA,
    REG_SET,
    REG_CLR,
    REG_CFG,
    REG_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] snap_o
);

  localparam int CNT_W = $clog2(STAGES + 1) + 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [CNT_W-1:0]             fill_q;
  logic                         snap_done_q;
  logic [WIDTH-1:0]             snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  // Snapshot waits until the synchronizer holds post-reset pin data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q      <= '0;
      snap_done_q <= 1'b0;
      snap_q      <= '0;
    end else if (fill_q < CNT_W'(STAGES)) begin
      fill_q <= fill_q + 1'b1;
    end else if (!snap_done_q) begin
      snap_q      <= stg_q[STAGES-1];
      snap_done_q <= 1'b1;
    end
  end

  assign snap_o = snap_q;

  AST_SNAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(snap_done_q) |-> $stable(snap_q)); // R5

  AST_SNAP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(snap_done_q) |-> snap_done_q); // R5

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_data_i,
  input  logic             wr_set_i,
  input  logic             wr_clr_i,
  input  logic [WIDTH-1:0] dir_wdata_i,
  input  logic [WIDTH-1:0] lvl_wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] lvl_o
);

  logic [WIDTH-1:0] dir_q, lvl_q, lvl_d;
  logic [WIDTH-1:0] set_mask, clr_mask;

  assign set_mask = wr_set_i ? lvl_wdata_i : '0;
  assign clr_mask = wr_clr_i ? lvl_wdata_i : '0;

  // Clear wins over set on the same bit
  always_comb begin
    if (wr_data_i) lvl_d = lvl_wdata_i;
    else           lvl_d = (lvl_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_data_i) dir_q <= dir_wdata_i;
      lvl_q <= lvl_d;
    end
  end

  assign dir_o = dir_q;
  assign lvl_o = lvl_q;

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (dir_q == $past(dir_wdata_i)) && (lvl_q == $past(lvl_wdata_i))); // R2

  AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set_i && !wr_clr_i && !wr_data_i) |=>
      (lvl_q == ($past(lvl_q) | $past(lvl_wdata_i))) && $stable(dir_q)); // R6

  AST_CLR_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_set_i && !wr_data_i) |=>
      (lvl_q == ($past(lvl_q) & ~$past(lvl_wdata_i))) && $stable(dir_q)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_data_i || wr_set_i || wr_clr_i) |=> $stable(lvl_q) && $stable(dir_q)); // R8

endmodule

// File: rtl/gpio_cfg_once.sv
module gpio_cfg_once #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] drv_wdata_i,
  input  logic [WIDTH-1:0] pud_wdata_i,
  output logic [WIDTH-1:0] drv_o,
  output logic [WIDTH-1:0] pud_o
);

  logic [WIDTH-1:0] drv_q, pud_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= '0;
      pud_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_i) begin
      pud_q  <= pud_wdata_i;
      lock_q <= 1'b1;
      if (!lock_q) drv_q <= drv_wdata_i;
    end
  end

  assign drv_o = drv_q;
  assign pud_o = pud_q;

  AST_DRV_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> $stable(drv_q)); // R10

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> lock_q); // R10

  AST_PUD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pud_q == $past(pud_wdata_i)); // R9

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] drv_o,
  output logic [NUM_PINS-1:0] pu_dis_o
);

  localparam int FW     = DATA_W / 4;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word_idx;
  reg_sel_e            reg_sel;
  logic                wr_data, wr_set, wr_clr, wr_cfg, rd_en;
  logic [NUM_PINS-1:0] sync_in, snap;
  logic [DATA_W-1:0]   rd_word, rdata_q;
  logic                unused_ok;

  assign word_idx  = addr_i[ADDR_W-1:2];
  assign unused_ok = ^{addr_i[1:0], wdata_i};

  always_comb begin
    if      (word_idx == WORD_W'(WORD_DATA)) reg_sel = REG_DATA;
    else if (word_idx == WORD_W'(WORD_SET))  reg_sel = REG_SET;
    else if (word_idx == WORD_W'(WORD_CLR))  reg_sel = REG_CLR;
    else if (word_idx == WORD_W'(WORD_CFG))  reg_sel = REG_CFG;
    else                                     reg_sel = REG_NONE;
  end

  assign wr_data = sel_i && we_i && (reg_sel == REG_DATA);
  assign wr_set  = sel_i && we_i && (reg_sel == REG_SET);
  assign wr_clr  = sel_i && we_i && (reg_sel == REG_CLR);
  assign wr_cfg  = sel_i && we_i && (reg_sel == REG_CFG);
  assign rd_en   = sel_i && !we_i;

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_in_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (sync_in),
    .snap_o (snap)
  );

  gpio_out_regs #(
    .WIDTH (NUM_PINS)
  ) i_out_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_data_i   (wr_data),
    .wr_set_i    (wr_set),
    .wr_clr_i    (wr_clr),
    .dir_wdata_i (wdata_i[LANE_DIR*FW +: NUM_PINS]),
    .lvl_wdata_i (wdata_i[LANE_OUT*FW +: NUM_PINS]),
    .dir_o       (oe_o),
    .lvl_o       (out_o)
  );

  gpio_cfg_once #(
    .WIDTH (NUM_PINS)
  ) i_cfg_once (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_cfg),
    .drv_wdata_i (wdata_i[LANE_DRV*FW +: NUM_PINS]),
    .pud_wdata_i (wdata_i[LANE_PUD*FW +: NUM_PINS]),
    .drv_o       (drv_o),
    .pud_o       (pu_dis_o)
  );

  always_comb begin
    rd_word = '0;
    case (reg_sel)
      REG_DATA: begin
        rd_word[LANE_DIR*FW  +: NUM_PINS] = oe_o;
        rd_word[LANE_OUT*FW  +: NUM_PINS] = out_o;
        rd_word[LANE_SNAP*FW +: NUM_PINS] = snap;
        rd_word[LANE_IN*FW   +: NUM_PINS] = sync_in;
      end
      REG_CFG: begin
        rd_word[LANE_DRV*FW +: NUM_PINS] = drv_o;
        rd_word[LANE_PUD*FW +: NUM_PINS] = pu_dis_o;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_word : '0;
  end

  assign rdata_o = rdata_q;

  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && (reg_sel inside {REG_SET, REG_CLR, REG_NONE})) |=> rdata_o == '0); // R8

  AST_DATA_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && reg_sel == REG_DATA) |=>
      rdata_o[LANE_DIR*FW +: NUM_PINS] == $past(oe_o)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (oe_o == '0) && (out_o == '0) && (rdata_o == '0)); // R1

endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  pin_i = '0;
  logic [7:0]  oe_o, out_o, drv_o, pu_dis_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_port_regs i_gpio_port_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pin_i    (pin_i),
    .oe_o     (oe_o),
    .out_o    (out_o),
    .drv_o    (drv_o),
    .pu_dis_o (pu_dis_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] p);
    rst_ni = 1'b0;
    pin_i  = p;
    repeat (3) @(negedge clk_i);
    check("R1 oe", {24'h0, oe_o}, 32'h0);
    check("R1 out", {24'h0, out_o}, 32'h0);
    check("R1 drv", {24'h0, drv_o}, 32'h0);
    check("R1 pud", {24'h0, pu_dis_o}, 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {oe_o, out_o, drv_o, pu_dis_o}, 32'h0);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  snap0, prev, a, dir;

    snap0 = 8'hA6;
    @(negedge clk_i);
    do_reset(snap0);

    // R5: snapshot from pins held across reset release
    bus_rd(5'h00, rd);
    check("R5 snapshot", {24'h0, rd[15:8]}, {24'h0, snap0});
    check("R3 input lane", {24'h0, rd[7:0]}, {24'h0, snap0});

    // R2/R3 sweep of direction and output
    for (int v = 0; v < 256; v++) begin
      bus_wr(5'h00, {v[7:0], ~v[7:0], 16'hFFFF});
      check("R2 oe", {24'h0, oe_o}, {24'h0, v[7:0]});
      check("R2 out", {24'h0, out_o}, {24'h0, ~v[7:0]});
      bus_rd(5'h00, rd);
      check("R3 data word", rd, {v[7:0], ~v[7:0], snap0, snap0});
    end

    // R6/R7 sweep of set and clear masks, reserved bits all ones
    for (int m = 0; m < 256; m++) begin
      a   = 8'(m * 37 + 11);
      dir = m[7:0] ^ 8'h5A;
      bus_wr(5'h00, {dir, a, 16'h0});
      bus_wr(5'h04, {8'hFF, m[7:0], 16'hFFFF});
      check("R6 set", {24'h0, out_o}, {24'h0, a | m[7:0]});
      check("R6 dir kept", {24'h0, oe_o}, {24'h0, dir});
      bus_wr(5'h00, {dir, a, 16'h0});
      bus_wr(5'h08, {8'hFF, m[7:0], 16'hFFFF});
      check("R7 clear", {24'h0, out_o}, {24'h0, a & ~m[7:0]});
      check("R7 dir kept", {24'h0, oe_o}, {24'h0, dir});
    end

    // R8: write-only aliases and unmapped words
    bus_wr(5'h00, 32'h3C_96_0000);
    bus_rd(5'h04, rd); check("R8 set reads zero", rd, 32'h0);
    bus_rd(5'h08, rd); check("R8 clr reads zero", rd, 32'h0);
    for (int w = 4; w < 8; w++) begin
      bus_wr(5'(w * 4), 32'hFFFF_FFFF);
      bus_rd(5'(w * 4), rd);
      check("R8 unmapped read", rd, 32'h0);
    end
    check("R8 unmapped write oe", {24'h0, oe_o}, 32'h3C);
    check("R8 unmapped write out", {24'h0, out_o}, 32'h96);
    check("R8 unmapped write cfg", {drv_o, pu_dis_o}, 16'h0);

    // R4: two-edge input latency, full pin sweep
    prev = snap0;
    for (int v = 0; v < 256; v++) begin
      pin_i = v[7:0];
      @(negedge clk_i);
      bus_rd(5'h00, rd);
      check("R4 old level", {24'h0, rd[7:0]}, {24'h0, prev});
      bus_rd(5'h00, rd);
      check("R4 new level", {24'h0, rd[7:0]}, {24'h0, v[7:0]});
      check("R5 snapshot held", {24'h0, rd[15:8]}, {24'h0, snap0});
      prev = v[7:0];
    end

    // R9/R10: write-once drive strength
    bus_wr(5'h0C, 32'hFFFF_A53C);
    check("R9 drv", {24'h0, drv_o}, 32'hA5);
    check("R9 pud", {24'h0, pu_dis_o}, 32'h3C);
    bus_rd(5'h0C, rd); check("R9 cfg read", rd, 32'h0000_A53C);
    bus_wr(5'h0C, 32'h0000_5AC3);
    check("R10 drv locked", {24'h0, drv_o}, 32'hA5);
    check("R9 pud rewritable", {24'h0, pu_dis_o}, 32'hC3);
    bus_rd(5'h0C, rd); check("R10 cfg read", rd, 32'h0000_A5C3);

    // R10/R5: reset rearms the lock and retakes the snapshot
    do_reset(8'h3C);
    bus_wr(5'h0C, 32'h0000_7711);
    check("R10 rearmed", {drv_o, pu_dis_o}, 16'h7711);
    bus_rd(5'h00, rd);
    check("R5 new snapshot", rd, 32'h0000_3C3C);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule